// File: doc/BRIEF.md
# Register-Transfer Function Unit

A purely combinational function unit that serves the datapath of a small load/store processor. It receives two data operands, A and B, and a 4-bit function select, and it returns a data result together with four status flags: negative, zero, carry and overflow. The controller drives the select code. It uses the negative and zero flags to resolve conditional branches, and it receives carry and overflow for its own use.

The operation set has four parts. Arithmetic on A covers pass, increment, add, subtract and decrement. Bitwise logic works on A and B. B can be passed through or shifted by one bit. All arithmetic shares one adder whose second input and carry-in are chosen by the select code. The data width is a parameter and defaults to 16 bits. Register file, memory, immediate selection and sequencing belong to other blocks.

Top module: `rt_func_unit`

## Requirements
- R1: Select 0000 drives the result with A unchanged, and carry and overflow are 0.
- R2: Select 0001 gives A+1 modulo 2^W; carry is 1 exactly when A is all ones; overflow is 1 exactly when A is the largest positive value.
- R3: Select 0010 gives A+B modulo 2^W; carry is the unsigned carry out; overflow is 1 when A and B have the same sign bit and the result's sign bit differs from it.
- R4: Select 0101 gives A−B, formed as A + NOT B + 1; carry is 1 when A ≥ B unsigned (no borrow); overflow is 1 when the sign bits of A and B differ and the result's sign bit differs from A's.
- R5: Select 0110 gives A−1 (A plus all ones); carry is 1 unless A is zero; overflow is 1 exactly when A is the most negative value.
- R6: Selects 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A; carry and overflow are 0.
- R7: Select 1100 drives the result with B unchanged, and carry and overflow are 0.
- R8: Select 1101 shifts B right by one and select 1110 shifts B left by one; the vacated bit is 0, and carry and overflow are 0.
- R9: For every select code the negative flag equals the result's most significant bit.
- R10: For every select code the zero flag is 1 exactly when all result bits are 0.
- R11: The unused selects 0011, 0100, 0111 and 1111 give a result of 0, with zero = 1 and negative, carry and overflow = 0.
- R12: Overflow can be 1 only for selects 0001, 0010, 0101 and 0110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| fsel_i | input | 4 | Function select code |
| res_o | output | W | Function result |
| neg_o | output | 1 | Result MSB |
| zero_o | output | 1 | Result is all zeros |
| carry_o | output | 1 | Carry out of the adder; 0 for non-arithmetic selects |
| ovf_o | output | 1 | Signed overflow of add-type selects |

## Verification
On every evaluation, the embedded assertions check several rules. Overflow stays low outside the four add-type codes. Subtract and decrement carry track the unsigned comparison of the operands. Pass-B returns B. Shifts never raise carry, and unused codes give a zero result. Exact result values of the arithmetic, logic and shift operations are shown only by the bench. Its behavioural reference model runs every select code against boundary operands, namely zero, all ones, the largest positive and most negative values, and alternating bit patterns, and then against random operands.

// File: rtl/fu_pkg.sv
package fu_pkg;

    localparam logic [3:0] FN_PASS_A = 4'b0000;
    localparam logic [3:0] FN_INC    = 4'b0001;
    localparam logic [3:0] FN_ADD    = 4'b0010;
    localparam logic [3:0] FN_SUB    = 4'b0101;
    localparam logic [3:0] FN_DEC    = 4'b0110;
    localparam logic [3:0] FN_AND    = 4'b1000;
    localparam logic [3:0] FN_OR     = 4'b1001;
    localparam logic [3:0] FN_XOR    = 4'b1010;
    localparam logic [3:0] FN_NOT_A  = 4'b1011;
    localparam logic [3:0] FN_PASS_B = 4'b1100;
    localparam logic [3:0] FN_SHR    = 4'b1101;
    localparam logic [3:0] FN_SHL    = 4'b1110;

    typedef enum logic [1:0] {
        GRP_NONE  = 2'd0,
        GRP_ARITH = 2'd1,
        GRP_LOGIC = 2'd2,
        GRP_SHIFT = 2'd3
    } fn_grp_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } fu_flags_t;

    function automatic fn_grp_e group_of(input logic [3:0] sel);
        fn_grp_e g;
        case (sel)
            FN_PASS_A, FN_INC, FN_ADD, FN_SUB, FN_DEC: g = GRP_ARITH;
            FN_AND, FN_OR, FN_XOR, FN_NOT_A:           g = GRP_LOGIC;
            FN_PASS_B, FN_SHR, FN_SHL:                 g = GRP_SHIFT;
            default:                                   g = GRP_NONE;
        endcase
        return g;
    endfunction

    function automatic logic is_add_type(input logic [3:0] sel);
        return (sel == FN_INC) || (sel == FN_ADD) || (sel == FN_SUB) || (sel == FN_DEC);
    endfunction

endpackage

// File: rtl/fu_arith.sv
module fu_arith
    import fu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);

    logic [W-1:0] addend;
    logic         cin;
    logic [W:0]   wide;

    // Operand conditioning: one adder serves all add-type selects.
    always_comb begin
        case (sel_i)
            FN_INC:  begin addend = '0;    cin = 1'b1; end
            FN_ADD:  begin addend = b_i;   cin = 1'b0; end
            FN_SUB:  begin addend = ~b_i;  cin = 1'b1; end
            FN_DEC:  begin addend = '1;    cin = 1'b0; end
            default: begin addend = '0;    cin = 1'b0; end
        endcase
    end

    assign wide   = {1'b0, a_i} + {1'b0, addend} + {{W{1'b0}}, cin};
    assign sum_o  = wide[W-1:0];
    assign cout_o = wide[W];
    assign ovf_o  = (a_i[W-1] == addend[W-1]) && (wide[W-1] != a_i[W-1]);

endmodule

// File: rtl/fu_logic.sv
module fu_logic #(
    parameter int W = 16
) (
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);

    always_comb begin
        case (op_i)
            2'b00:   y_o = a_i & b_i;
            2'b01:   y_o = a_i | b_i;
            2'b10:   y_o = a_i ^ b_i;
            default: y_o = ~a_i;
        endcase
    end

endmodule

// File: rtl/fu_shift.sv
module fu_shift #(
    parameter int W = 16
) (
    input  logic [1:0]   op_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);

    logic [W-1:0] right_y;
    logic [W-1:0] left_y;

    // Per-bit neighbour selection with zero fill at the vacated end.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == W - 1) begin : g_top
            assign right_y[i] = 1'b0;
        end else begin : g_mid_r
            assign right_y[i] = b_i[i+1];
        end
        if (i == 0) begin : g_bot
            assign left_y[i] = 1'b0;
        end else begin : g_mid_l
            assign left_y[i] = b_i[i-1];
        end
    end

    always_comb begin
        case (op_i)
            2'b00:   y_o = b_i;
            2'b01:   y_o = right_y;
            2'b10:   y_o = left_y;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/fu_flags.sv
module fu_flags
    import fu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] res_i,
    input  logic         c_i,
    input  logic         v_i,
    output fu_flags_t    flags_o
);

    assign flags_o.n = res_i[W-1];
    assign flags_o.z = ~|res_i;
    assign flags_o.c = c_i;
    assign flags_o.v = v_i;

endmodule

// File: rtl/rt_func_unit.sv
module rt_func_unit
    import fu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   fsel_i,
    output logic [W-1:0] res_o,
    output logic         neg_o,
    output logic         zero_o,
    output logic         carry_o,
    output logic         ovf_o
);

    fn_grp_e      grp;
    logic [W-1:0] arith_y;
    logic         arith_c;
    logic         arith_v;
    logic [W-1:0] logic_y;
    logic [W-1:0] shift_y;
    logic [W-1:0] res_sel;
    logic         c_sel;
    logic         v_sel;
    fu_flags_t    flags;

    assign grp = group_of(fsel_i);

    fu_arith #(.W(W)) u_arith (
        .sel_i (fsel_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .sum_o (arith_y),
        .cout_o(arith_c),
        .ovf_o (arith_v)
    );

    fu_logic #(.W(W)) u_logic (
        .op_i(fsel_i[1:0]),
        .a_i (a_i),
        .b_i (b_i),
        .y_o (logic_y)
    );

    fu_shift #(.W(W)) u_shift (
        .op_i(fsel_i[1:0]),
        .b_i (b_i),
        .y_o (shift_y)
    );

    always_comb begin
        res_sel = '0;
        c_sel   = 1'b0;
        v_sel   = 1'b0;
        case (grp)
            GRP_ARITH: begin
                res_sel = arith_y;
                c_sel   = arith_c;
                v_sel   = arith_v;
            end
            GRP_LOGIC: res_sel = logic_y;
            GRP_SHIFT: res_sel = shift_y;
            default:   res_sel = '0;
        endcase
    end

    fu_flags #(.W(W)) u_flags (
        .res_i  (res_sel),
        .c_i    (c_sel),
        .v_i    (v_sel),
        .flags_o(flags)
    );

    assign res_o   = res_sel;
    assign neg_o   = flags.n;
    assign zero_o  = flags.z;
    assign carry_o = flags.c;
    assign ovf_o   = flags.v;

    // Cross-unit checks, evaluated whenever operands and select are known.
    always_comb begin
        if (!$isunknown({fsel_i, a_i, b_i})) begin
            if (!is_add_type(fsel_i)) begin
                p_no_overflow_r12: assert (!ovf_o)
                    else $error("overflow raised for non add-type select");
            end
            if (fsel_i == FN_SUB) begin
                p_sub_no_borrow_r4: assert (carry_o == (a_i >= b_i))
                    else $error("subtract carry disagrees with unsigned compare");
            end
            if (fsel_i == FN_DEC) begin
                p_dec_carry_r5: assert (carry_o == (a_i != '0))
                    else $error("decrement carry wrong");
            end
            if (fsel_i == FN_PASS_B) begin
                p_pass_b_r7: assert (res_o == b_i)
                    else $error("pass B result differs from B");
            end
            if (fsel_i == FN_SHR || fsel_i == FN_SHL) begin
                p_shift_no_carry_r8: assert (!carry_o)
                    else $error("shift raised carry");
            end
            if (grp == GRP_NONE) begin
                p_unused_zero_r11: assert (res_o == '0 && zero_o && !carry_o)
                    else $error("unused select gave non-zero output");
            end
        end
    end

endmodule

// File: tb/sim_rt_func_unit.sv
module sim_rt_func_unit;

    localparam int W   = 16;
    localparam int MAXU = (1 << W) - 1;
    localparam int SMAX = (1 << (W - 1)) - 1;
    localparam int SMIN = -(1 << (W - 1));

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic [3:0]   sel = 4'b0000;
    logic [W-1:0] res;
    logic         neg, zero, carry, ovf;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    rt_func_unit #(.W(W)) u0 (
        .a_i    (a),
        .b_i    (b),
        .fsel_i (sel),
        .res_o  (res),
        .neg_o  (neg),
        .zero_o (zero),
        .carry_o(carry),
        .ovf_o  (ovf)
    );

    function automatic string req_of(input logic [3:0] s);
        case (s)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0101: return "R4";
            4'b0110: return "R5";
            4'b1000, 4'b1001, 4'b1010, 4'b1011: return "R6";
            4'b1100: return "R7";
            4'b1101, 4'b1110: return "R8";
            default: return "R11";
        endcase
    endfunction

    // Behavioural reference using integer arithmetic.
    task automatic model(input logic [3:0] s, input logic [W-1:0] x, input logic [W-1:0] y,
                         output logic [W-1:0] r, output logic c, output logic v);
        int ux, uy, sx, sy, t, st;
        logic arith;
        ux = int'(x);
        uy = int'(y);
        sx = int'($signed(x));
        sy = int'($signed(y));
        c = 1'b0; v = 1'b0; arith = 1'b0; t = 0; st = 0;
        r = '0;
        case (s)
            4'b0000: r = x;
            4'b0001: begin t = ux + 1;    st = sx + 1;  arith = 1'b1; end
            4'b0010: begin t = ux + uy;   st = sx + sy; arith = 1'b1; end
            4'b0101: begin t = ux - uy + MAXU + 1; st = sx - sy; arith = 1'b1; end
            4'b0110: begin t = ux + MAXU; st = sx - 1;  arith = 1'b1; end
            4'b1000: r = x & y;
            4'b1001: r = x | y;
            4'b1010: r = x ^ y;
            4'b1011: r = ~x;
            4'b1100: r = y;
            4'b1101: r = y >> 1;
            4'b1110: r = y << 1;
            default: r = '0;
        endcase
        if (arith) begin
            r = t[W-1:0];
            c = (t > MAXU);
            v = (st > SMAX) || (st < SMIN);
        end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] s, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] er;
        logic ec, ev;
        string tag;
        @(posedge clk);
        #2;
        sel = s; a = x; b = y;
        @(negedge clk);
        model(s, x, y, er, ec, ev);
        tag = req_of(s);
        check(tag, $sformatf("sel=%b result", s), int'(res), int'(er));
        check(tag, $sformatf("sel=%b carry", s), int'(carry), int'(ec));
        check(tag, $sformatf("sel=%b overflow", s), int'(ovf), int'(ev));
        check("R9",  $sformatf("sel=%b negative", s), int'(neg), int'(er[W-1]));
        check("R10", $sformatf("sel=%b zero", s), int'(zero), int'(er == '0));
        if (!(s == 4'b0001 || s == 4'b0010 || s == 4'b0101 || s == 4'b0110))
            check("R12", $sformatf("sel=%b overflow idle", s), int'(ovf), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    logic [W-1:0] pa [8];
    logic [W-1:0] pb [8];

    initial begin : main
        pa[0] = 16'h0000; pb[0] = 16'h0000;
        pa[1] = 16'hFFFF; pb[1] = 16'h0001;
        pa[2] = 16'h7FFF; pb[2] = 16'h0001;
        pa[3] = 16'h8000; pb[3] = 16'h8000;
        pa[4] = 16'h8000; pb[4] = 16'h0001;
        pa[5] = 16'h1234; pb[5] = 16'h1234;
        pa[6] = 16'h0000; pb[6] = 16'h0001;
        pa[7] = 16'hAAAA; pb[7] = 16'h5555;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset-time state with all inputs at zero: pass A of zero (R1, R10).
        check("R1",  "reset result", int'(res), 0);
        check("R10", "reset zero flag", int'(zero), 1);
        rst = 1'b0;

        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 8; k++) begin
                run(4'(s), pa[k], pb[k]);
            end
        end

        // Specific corners: R2 wrap, R5 most negative, R8 fill bits.
        run(4'b0001, 16'hFFFF, 16'h0000);
        check("R2", "increment wrap carry", int'(carry), 1);
        run(4'b0110, 16'h8000, 16'h0000);
        check("R5", "decrement most negative overflow", int'(ovf), 1);
        run(4'b1101, 16'hFFFF, 16'hFFFF);
        check("R8", "shift right fills 0", int'(res), 16'h7FFF);
        run(4'b1110, 16'h0000, 16'hFFFF);
        check("R8", "shift left fills 0", int'(res), 16'hFFFE);
        run(4'b0101, 16'h0003, 16'h0005);
        check("R4", "subtract borrow clears carry", int'(carry), 0);

        for (int i = 0; i < 400; i++) begin
            run(4'($urandom_range(0, 15)), W'($urandom), W'($urandom));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule